// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits between a PWM generator and the output pins. When an active-low fault input goes low, every PWM output is replaced by a programmed safe level taken from a per-output fault-level vector. Recovery to normal switching is never immediate. It waits for the release conditions to be met and then for the next full-cycle or half-cycle boundary pulse from the time base.

There are two recovery behaviours, chosen by a mode bit. In latched mode the override holds until the pin is high and software has cleared the fault flag. In cycle-by-cycle mode the override follows the pin, and the flag has no effect on recovery. Software can also force the override through a control input. A fault that arrives while the system sleeps raises a wake request.

Top module: `pwm_fault_ctl`

## Requirements
- R1: Once the raw fault pin `flt_n` is low, `pwm_out` equals `safe_lvl` from the second rising clock edge onward (two-flop synchronizer), and it stays there while the pin is low.
- R2: A synchronized falling edge of the pin sets `flt_flag` at the third rising edge after the pin falls. The flag stays set until `flag_clr` is pulsed. A new falling edge in the same cycle takes priority over the clear.
- R3: With `latch_mode` = 1, the override holds across boundary pulses while `flt_flag` is set, even after the pin has returned high.
- R4: With `latch_mode` = 1, clearing the flag while the pin is still low does not end the override. Once the pin is high and the flag is clear, the override ends at the first boundary pulse.
- R5: With `latch_mode` = 0, the override ends at the first boundary pulse after the synchronized pin is high, whatever the state of `flt_flag`.
- R6: The override never ends without a boundary pulse. Either `cyc_bnd` or `half_bnd` counts as one, and the outputs follow `pwm_in` from the edge where the pulse is sampled.
- R7: While `sw_fault` = 1, `pwm_out` equals `safe_lvl`. After `sw_fault` drops, the override ends at the next boundary pulse. `sw_fault` does not set `flt_flag`.
- R8: A synchronized falling edge of the pin while `sleep` = 1 sets `wake_req` on the same edge as the flag. `wake_req` clears when `sleep` is 0. A fault outside sleep does not raise it.
- R9: After reset, `pwm_out` follows `pwm_in` and `flt_flag` and `wake_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | N_OUT | Raw PWM outputs from the generator |
| safe_lvl | input | N_OUT | Level driven on each output during the override |
| flt_n | input | 1 | Asynchronous fault pin, active low |
| latch_mode | input | 1 | 1 = latched recovery, 0 = cycle-by-cycle recovery |
| flag_clr | input | 1 | Software strobe that clears the fault flag |
| sw_fault | input | 1 | Software-forced fault |
| cyc_bnd | input | 1 | Full-cycle boundary pulse |
| half_bnd | input | 1 | Half-cycle boundary pulse |
| sleep | input | 1 | System sleep state |
| pwm_out | output | N_OUT | Gated PWM outputs |
| flt_flag | output | 1 | Fault interrupt flag |
| wake_req | output | 1 | Wake request raised by a fault during sleep |

## Verification
A pin change reaches `pwm_out` two rising edges after it is driven. `flt_flag` and `wake_req` follow one edge later. A boundary pulse releases the outputs at the edge where it is sampled. `sw_fault` acts on `pwm_out` at once, with no edge in between. The bench drives every input just after a falling edge and samples at falling edges. It waits exactly these numbers of edges before each check, and it waits at least three edges after a pin release before it sends a boundary pulse, so the synchronizer has settled.

// File: rtl/pwm_fault_ctl.sv
module pwm_fault_ctl #(
  parameter int N_OUT = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] pwm_in,
  input  logic [N_OUT-1:0] safe_lvl,
  input  logic             flt_n,
  input  logic             latch_mode,
  input  logic             flag_clr,
  input  logic             sw_fault,
  input  logic             cyc_bnd,
  input  logic             half_bnd,
  input  logic             sleep,
  output logic [N_OUT-1:0] pwm_out,
  output logic             flt_flag,
  output logic             wake_req
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_prev;
  logic                   ovr_q;

  wire pin_lo    = ~sync_q[SYNC_STAGES-1];
  wire pin_fall  = pin_prev & pin_lo;
  wire fault_now = pin_lo | sw_fault;
  wire boundary  = cyc_bnd | half_bnd;
  wire rel_ok    = latch_mode ? ~flt_flag : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q   <= '1;
      pin_prev <= 1'b1;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], flt_n};
      pin_prev <= sync_q[SYNC_STAGES-1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       ovr_q <= 1'b0;
    else if (fault_now)               ovr_q <= 1'b1;
    else if (ovr_q && rel_ok && boundary) ovr_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         flt_flag <= 1'b0;
    else if (pin_fall)  flt_flag <= 1'b1;
    else if (flag_clr)  flt_flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  wake_req <= 1'b0;
    else if (!sleep)             wake_req <= 1'b0;
    else if (pin_fall)           wake_req <= 1'b1;

  assign pwm_out = (ovr_q | fault_now) ? safe_lvl : pwm_in;

endmodule

module pwm_fault_ctl_chk #(
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] pwm_out,
  input logic [N_OUT-1:0] safe_lvl,
  input logic             ovr_q,
  input logic             pin_fall,
  input logic             flt_flag,
  input logic             wake_req,
  input logic             sleep,
  input logic             latch_mode,
  input logic             flag_clr,
  input logic             cyc_bnd,
  input logic             half_bnd
);

  p_forced_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> pwm_out == safe_lvl);

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |=> flt_flag);

  p_flag_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !pin_fall) |=> !flt_flag);

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && latch_mode && flt_flag) |=> ovr_q);

  p_release_bnd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !cyc_bnd && !half_bnd) |=> ovr_q);

  p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_fall && sleep) |=> wake_req);

  p_wake_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> !wake_req);

endmodule

bind pwm_fault_ctl pwm_fault_ctl_chk #(.N_OUT(N_OUT)) chk_i (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .safe_lvl(safe_lvl),
  .ovr_q(ovr_q), .pin_fall(pin_fall), .flt_flag(flt_flag),
  .wake_req(wake_req), .sleep(sleep), .latch_mode(latch_mode),
  .flag_clr(flag_clr), .cyc_bnd(cyc_bnd), .half_bnd(half_bnd)
);

// File: tb/pwm_fault_ctl_tb_top.sv
module pwm_fault_ctl_tb_top;
  localparam int N = 4;
  localparam logic [N-1:0] PWM  = 4'b1010;
  localparam logic [N-1:0] SAFE = 4'b0110;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pwm_in = PWM, safe_lvl = SAFE;
  logic flt_n = 1, latch_mode = 0, flag_clr = 0, sw_fault = 0;
  logic cyc_bnd = 0, half_bnd = 0, sleep = 0;
  logic [N-1:0] pwm_out;
  logic flt_flag, wake_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_fault_ctl #(.N_OUT(N)) dut_i (.*);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_bnd(bit half);
    if (half) half_bnd = 1; else cyc_bnd = 1;
    step(1);
    cyc_bnd = 0; half_bnd = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; step(1); flag_clr = 0;
  endtask

  task automatic t_reset();
    chk("R9 out", pwm_out, PWM);
    chk("R9 flag", flt_flag, 0);
    chk("R9 wake", wake_req, 0);
  endtask

  task automatic t_cbc();
    latch_mode = 0;
    flt_n = 0; step(1);
    chk("R1 not yet", pwm_out, PWM);
    step(1);
    chk("R1 forced", pwm_out, SAFE);
    chk("R2 flag not yet", flt_flag, 0);
    step(1);
    chk("R2 flag set", flt_flag, 1);
    pulse_bnd(0);
    chk("R1 held while low", pwm_out, SAFE);
    flt_n = 1; step(4);
    chk("R6 no release without boundary", pwm_out, SAFE);
    pulse_bnd(1);
    chk("R5 released with flag set", pwm_out, PWM);
    chk("R5 flag still set", flt_flag, 1);
    clear_flag();
    chk("R2 flag cleared", flt_flag, 0);
  endtask

  task automatic t_latched();
    latch_mode = 1;
    flt_n = 0; step(3);
    chk("R2 flag latched", flt_flag, 1);
    flt_n = 1; step(3);
    pulse_bnd(0);
    chk("R3 hold with flag set", pwm_out, SAFE);
    clear_flag();
    chk("R6 hold until boundary", pwm_out, SAFE);
    pulse_bnd(0);
    chk("R4 release after clear", pwm_out, PWM);
  endtask

  task automatic t_latched_early_clr();
    latch_mode = 1;
    flt_n = 0; step(3);
    clear_flag();
    chk("R2 clear while low", flt_flag, 0);
    pulse_bnd(0);
    chk("R4 hold while pin low", pwm_out, SAFE);
    flt_n = 1; step(3);
    pwm_in = 4'b0001;
    pulse_bnd(1);
    chk("R4 release on half boundary", pwm_out, 4'b0001);
    pwm_in = PWM;
  endtask

  task automatic t_sw();
    latch_mode = 1;
    sw_fault = 1; #1;
    chk("R7 forced at once", pwm_out, SAFE);
    step(2);
    chk("R7 no flag", flt_flag, 0);
    sw_fault = 0; step(2);
    chk("R7 held to boundary", pwm_out, SAFE);
    pulse_bnd(0);
    chk("R7 released", pwm_out, PWM);
  endtask

  task automatic t_sleep();
    latch_mode = 0;
    flt_n = 0; step(3);
    chk("R8 no wake when awake", wake_req, 0);
    flt_n = 1; step(3); pulse_bnd(0); clear_flag();
    sleep = 1; step(1);
    flt_n = 0; step(2);
    chk("R8 wake not yet", wake_req, 0);
    step(1);
    chk("R8 wake set", wake_req, 1);
    flt_n = 1; step(3);
    chk("R8 wake held in sleep", wake_req, 1);
    sleep = 0; step(1);
    chk("R8 wake cleared", wake_req, 0);
    pulse_bnd(0); clear_flag();
    chk("R5 normal after sleep test", pwm_out, PWM);
  endtask

  initial begin
    step(2); rst_n = 1; step(1);
    t_reset();
    t_cbc();
    t_latched();
    t_latched_early_clr();
    t_sw();
    t_sleep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule